// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a packet memory that is cut into 256-byte pages. Every packet takes a whole number of pages and is known by a small packet number. A host drives one command register to allocate packets by page count, to drop or free received packets, to queue packets for sending, and to clear transmit or whole-pool state. The memory contents, the MAC and the line side are outside the block. The block only tracks who owns each packet number and how many pages it holds.

The receive side asks for pages through its own request pin. Numbers it obtains go into a receive FIFO that the host drains. The transmit side reports each finished packet. A good send returns the packet to the pool at once. A failed send is parked in a transmit-done FIFO for the host to inspect. A host allocation that cannot be met stays pending and is retried on each later cycle. When it finally succeeds, the block raises a completion pulse.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, busy_o, alloc_done_o, tx_req_o and rx_drop_o are 0 and alloc_res_o is 0x00. mem_info_o reads NUM_PAGES in both bytes, and fifo_status_o reads 0x8080 (both FIFOs empty).
- R2: A write of opcode 1 (cmd_i[7:5]=1) asks for cmd_i[4:0]+1 pages. busy_o is high in the cycle after the write. One cycle later, alloc_res_o holds the lowest free packet number in bits 6:0 with bit 7 clear.
- R3: If the pages or packet numbers do not suffice, alloc_res_o reads 0x80 and the request stays pending. It is retried every cycle in which the receive side makes no request. A late success loads the number into alloc_res_o and pulses alloc_done_o for one cycle. An immediate success gives no pulse.
- R4: mem_info_o[7:0] is NUM_PAGES. mem_info_o[15:8] is NUM_PAGES minus the pages held by all packets that are not free. It changes at the clock edge that completes any allocation or free.
- R5: rx_alloc_i asks for rx_pages_i+1 pages. On success, the lowest free number is pushed into the receive FIFO. Otherwise rx_drop_o pulses in the next cycle. fifo_status_o[14:8] shows the receive head, and bit 15 is its empty flag. The number field reads 0 when the FIFO is empty.
- R6: Opcode 4 pops the receive head and hands it to the host without freeing its pages. Opcode 5 pops the head and frees its pages. Both have no effect on an empty receive FIFO.
- R7: Opcode 6 queues packet pkt_sel_i for sending if the host owns it. tx_req_o then pulses in the next cycle with tx_pkt_o equal to pkt_sel_i. For any other packet the command is ignored.
- R8: tx_done_i for a queued packet frees it when tx_ok_i is 1. When tx_ok_i is 0, the number is pushed into the transmit-done FIFO, shown in fifo_status_o[6:0] with empty flag bit 7.
- R9: Opcode 7 frees every queued or failed transmit packet and empties the transmit-done FIFO.
- R10: Opcode 2 empties both FIFOs and cancels any pending allocation. It then keeps busy_o high for exactly NUM_PKTS cycles while every packet returns to the pool. Receive requests made during that time are dropped.
- R11: A command written while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command: opcode in bits 7:5, page count minus one in bits 4:0 |
| pkt_sel_i | input | 7 | Packet number selected for the queue command |
| rx_alloc_i | input | 1 | Receive side page request |
| rx_pages_i | input | 5 | Receive page count minus one |
| rx_drop_o | output | 1 | Receive request could not be met |
| tx_done_i | input | 1 | Transmit side finished a packet |
| tx_done_pkt_i | input | 7 | Number of the finished packet |
| tx_ok_i | input | 1 | Finished packet was sent without error |
| tx_req_o | output | 1 | Packet handed to the transmit side |
| tx_pkt_o | output | 7 | Number of the handed-over packet |
| busy_o | output | 1 | Command still executing |
| alloc_done_o | output | 1 | Deferred allocation completed |
| alloc_res_o | output | 8 | Allocation result, bit 7 = failed |
| fifo_status_o | output | 16 | {rx empty, rx head, tx-done empty, tx-done head} |
| mem_info_o | output | 16 | {free pages, total pages} |

## Verification
The hardest situation to reach is a pending allocation that completes later. It needs a pool that is first exhausted, by pages in one sweep and by packet numbers in another. A failed request must sit pending, and then pages must come back through the transmit path alone. The stimulus fills the pool with growing page counts, queues and completes one packet, and checks the free count, the result byte and the single alloc_done_o pulse one edge apart. A pending request is also left in place across a pool reset, and commands and receive requests are fired into the busy window to show they are discarded.

// File: rtl/pba_pkg.sv
`timescale 1ns/1ps
package pba_pkg;
  typedef enum logic [2:0] {PS_FREE, PS_HOST, PS_TXQ, PS_TXFAIL, PS_RX} pkt_state_e;
  localparam logic [2:0] OP_ALLOC   = 3'd1;
  localparam logic [2:0] OP_RESET   = 3'd2;
  localparam logic [2:0] OP_RX_REL  = 3'd4;
  localparam logic [2:0] OP_RX_FREE = 3'd5;
  localparam logic [2:0] OP_ENQ     = 3'd6;
  localparam logic [2:0] OP_TX_RST  = 3'd7;
endpackage

// File: rtl/pba_fifo.sv
`timescale 1ns/1ps
module pba_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/pba_pool.sv
`timescale 1ns/1ps
module pba_pool #(
  parameter int NUM_PKTS = 16,
  parameter int PG_W     = 6,
  parameter int SUM_W    = 10,
  parameter int IDX_W    = $clog2(NUM_PKTS)
) (
  input  logic [NUM_PKTS-1:0]      free_i,
  input  logic [NUM_PKTS*PG_W-1:0] pages_i,
  output logic                     any_free_o,
  output logic [IDX_W-1:0]         first_o,
  output logic [SUM_W-1:0]         used_o
);
  logic [SUM_W-1:0] held [NUM_PKTS];

  for (genvar g = 0; g < NUM_PKTS; g++) begin : g_held
    assign held[g] = free_i[g] ? '0 : SUM_W'(pages_i[g*PG_W +: PG_W]);
  end

  always_comb begin
    used_o = '0;
    for (int i = 0; i < NUM_PKTS; i++) used_o = used_o + held[i];
  end

  // lowest free number wins
  always_comb begin
    first_o = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (free_i[i]) first_o = IDX_W'(i);
    end
  end

  assign any_free_o = |free_i;
endmodule

// File: rtl/pkt_page_alloc.sv
`timescale 1ns/1ps
module pkt_page_alloc
  import pba_pkg::*;
#(
  parameter int NUM_PKTS  = 16,
  parameter int NUM_PAGES = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_i,
  input  logic [6:0]  pkt_sel_i,
  input  logic        rx_alloc_i,
  input  logic [4:0]  rx_pages_i,
  output logic        rx_drop_o,
  input  logic        tx_done_i,
  input  logic [6:0]  tx_done_pkt_i,
  input  logic        tx_ok_i,
  output logic        tx_req_o,
  output logic [6:0]  tx_pkt_o,
  output logic        busy_o,
  output logic        alloc_done_o,
  output logic [7:0]  alloc_res_o,
  output logic [15:0] fifo_status_o,
  output logic [15:0] mem_info_o
);
  localparam int IDX_W = $clog2(NUM_PKTS);
  localparam int PG_W  = 6;
  localparam int SUM_W = $clog2(NUM_PKTS * 32 + NUM_PAGES + 1);

  pkt_state_e       st_q [NUM_PKTS];
  logic [PG_W-1:0]  pg_q [NUM_PKTS];
  logic             pend_q, pend_first_q, clr_q;
  logic [PG_W-1:0]  need_q;
  logic [IDX_W-1:0] clr_idx_q;
  logic [7:0]       res_q;
  logic             done_q, tx_req_q, rx_drop_q;
  logic [6:0]       tx_pkt_q;

  logic [NUM_PKTS-1:0]      free_vec;
  logic [NUM_PKTS*PG_W-1:0] pages_flat;
  logic                     any_free;
  logic [IDX_W-1:0]         first_free;
  logic [SUM_W-1:0]         used_pages, free_pages;

  for (genvar g = 0; g < NUM_PKTS; g++) begin : g_flat
    assign free_vec[g] = (st_q[g] == PS_FREE);
    assign pages_flat[g*PG_W +: PG_W] = pg_q[g];
  end

  pba_pool #(.NUM_PKTS(NUM_PKTS), .PG_W(PG_W), .SUM_W(SUM_W), .IDX_W(IDX_W)) i_pool (
    .free_i    (free_vec),
    .pages_i   (pages_flat),
    .any_free_o(any_free),
    .first_o   (first_free),
    .used_o    (used_pages)
  );

  assign free_pages = SUM_W'(NUM_PAGES) - used_pages;

  logic [2:0]       op;
  logic             cmd_ok;
  logic [PG_W-1:0]  rx_need;
  logic             rx_fit, host_fit, try_alloc;
  logic             sel_ok, txd_ok;
  logic [IDX_W-1:0] sel_idx, txd_idx;
  logic             rx_empty, txf_empty;
  logic [IDX_W-1:0] rx_head, txf_head;
  logic             rx_push, rx_pop, txf_push, rx_flush, txf_flush;

  assign op        = cmd_i[7:5];
  assign cmd_ok    = cmd_we_i && !busy_o;
  assign rx_need   = PG_W'(rx_pages_i) + 1'b1;
  assign rx_fit    = !clr_q && any_free && (SUM_W'(rx_need) <= free_pages);
  assign host_fit  = any_free && (SUM_W'(need_q) <= free_pages);
  assign try_alloc = pend_q && !rx_alloc_i && !clr_q;
  assign sel_ok    = pkt_sel_i < 7'(NUM_PKTS);
  assign sel_idx   = pkt_sel_i[IDX_W-1:0];
  assign txd_ok    = tx_done_i && !clr_q && (tx_done_pkt_i < 7'(NUM_PKTS))
                     && (st_q[txd_idx] == PS_TXQ);
  assign txd_idx   = tx_done_pkt_i[IDX_W-1:0];

  assign rx_push   = rx_alloc_i && rx_fit;
  assign rx_pop    = cmd_ok && (op == OP_RX_REL || op == OP_RX_FREE) && !rx_empty;
  assign rx_flush  = cmd_ok && (op == OP_RESET);
  assign txf_push  = txd_ok && !tx_ok_i;
  assign txf_flush = cmd_ok && (op == OP_RESET || op == OP_TX_RST);

  pba_fifo #(.DEPTH(NUM_PKTS), .W(IDX_W)) i_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .push_i(rx_push), .data_i(first_free),
    .pop_i(rx_pop), .head_o(rx_head), .empty_o(rx_empty)
  );

  pba_fifo #(.DEPTH(NUM_PKTS), .W(IDX_W)) i_txd_fifo (
    .clk_i, .rst_ni,
    .flush_i(txf_flush), .push_i(txf_push), .data_i(txd_idx),
    .pop_i(1'b0), .head_o(txf_head), .empty_o(txf_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PKTS; i++) begin
        st_q[i] <= PS_FREE;
        pg_q[i] <= '0;
      end
      pend_q       <= 1'b0;
      pend_first_q <= 1'b0;
      need_q       <= '0;
      clr_q        <= 1'b0;
      clr_idx_q    <= '0;
      res_q        <= '0;
      done_q       <= 1'b0;
      tx_req_q     <= 1'b0;
      tx_pkt_q     <= '0;
      rx_drop_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      tx_req_q  <= 1'b0;
      rx_drop_q <= 1'b0;

      // pool clear walks one entry per cycle
      if (clr_q) begin
        st_q[clr_idx_q] <= PS_FREE;
        clr_idx_q       <= clr_idx_q + 1'b1;
        if (clr_idx_q == IDX_W'(NUM_PKTS - 1)) clr_q <= 1'b0;
      end

      if (txd_ok) st_q[txd_idx] <= tx_ok_i ? PS_FREE : PS_TXFAIL;

      if (rx_alloc_i) begin
        if (rx_fit) begin
          st_q[first_free] <= PS_RX;
          pg_q[first_free] <= rx_need;
        end else begin
          rx_drop_q <= 1'b1;
        end
      end

      if (try_alloc) begin
        pend_first_q <= 1'b0;
        if (host_fit) begin
          st_q[first_free] <= PS_HOST;
          pg_q[first_free] <= need_q;
          res_q            <= {1'b0, 7'(first_free)};
          pend_q           <= 1'b0;
          done_q           <= !pend_first_q;
        end else if (pend_first_q) begin
          res_q <= 8'h80;
        end
      end

      if (cmd_ok) begin
        case (op)
          OP_ALLOC: begin
            pend_q       <= 1'b1;
            pend_first_q <= 1'b1;
            need_q       <= PG_W'(cmd_i[4:0]) + 1'b1;
          end
          OP_RESET: begin
            clr_q        <= 1'b1;
            clr_idx_q    <= '0;
            pend_q       <= 1'b0;
            pend_first_q <= 1'b0;
          end
          OP_RX_REL:  if (!rx_empty) st_q[rx_head] <= PS_HOST;
          OP_RX_FREE: if (!rx_empty) st_q[rx_head] <= PS_FREE;
          OP_ENQ: begin
            if (sel_ok && st_q[sel_idx] == PS_HOST) begin
              st_q[sel_idx] <= PS_TXQ;
              tx_req_q      <= 1'b1;
              tx_pkt_q      <= pkt_sel_i;
            end
          end
          OP_TX_RST: begin
            for (int i = 0; i < NUM_PKTS; i++) begin
              if (st_q[i] == PS_TXQ || st_q[i] == PS_TXFAIL) st_q[i] <= PS_FREE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o        = pend_first_q | clr_q;
  assign alloc_done_o  = done_q;
  assign alloc_res_o   = res_q;
  assign tx_req_o      = tx_req_q;
  assign tx_pkt_o      = tx_pkt_q;
  assign rx_drop_o     = rx_drop_q;
  assign mem_info_o    = {8'(free_pages), 8'(NUM_PAGES)};
  assign fifo_status_o = {rx_empty,  rx_empty  ? 7'd0 : 7'(rx_head),
                          txf_empty, txf_empty ? 7'd0 : 7'(txf_head)};
endmodule

// File: rtl/pba_chk.sv
`timescale 1ns/1ps
module pba_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [2:0]  cmd_op_i,
  input logic        rx_alloc_i,
  input logic        busy_o,
  input logic        alloc_done_o,
  input logic        alloc_fail_o,
  input logic        tx_req_o,
  input logic        rx_drop_o,
  input logic [15:0] fifo_status_o,
  input logic [15:0] mem_info_o
);
  // R3
  done_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_done_o |-> !alloc_fail_o);

  // R4
  free_le_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_info_o[15:8] <= mem_info_o[7:0]);

  // R10
  reset_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o && cmd_op_i == 3'd2) |=> busy_o);

  // R7
  tx_req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> $past(cmd_we_i && !busy_o && cmd_op_i == 3'd6));

  // R5
  rx_drop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_o |-> $past(rx_alloc_i));

  // R5
  rx_empty_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_status_o[15] |-> fifo_status_o[14:8] == 7'd0);

  // R8
  txd_empty_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_status_o[7] |-> fifo_status_o[6:0] == 7'd0);
endmodule

bind pkt_page_alloc pba_chk i_pba_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_op_i     (cmd_i[7:5]),
  .rx_alloc_i   (rx_alloc_i),
  .busy_o       (busy_o),
  .alloc_done_o (alloc_done_o),
  .alloc_fail_o (alloc_res_o[7]),
  .tx_req_o     (tx_req_o),
  .rx_drop_o    (rx_drop_o),
  .fifo_status_o(fifo_status_o),
  .mem_info_o   (mem_info_o)
);

// File: tb/test_pkt_page_alloc.sv
`timescale 1ns/1ps
module test_pkt_page_alloc;
  localparam int NP = 16;
  localparam int PG = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [6:0]  pkt_sel_i = '0;
  logic        rx_alloc_i = 1'b0;
  logic [4:0]  rx_pages_i = '0;
  logic        tx_done_i = 1'b0;
  logic [6:0]  tx_done_pkt_i = '0;
  logic        tx_ok_i = 1'b0;
  logic        rx_drop_o, tx_req_o, busy_o, alloc_done_o;
  logic [6:0]  tx_pkt_o;
  logic [7:0]  alloc_res_o;
  logic [15:0] fifo_status_o, mem_info_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pkt_page_alloc #(.NUM_PKTS(NP), .NUM_PAGES(PG)) i_pkt_page_alloc (
    .clk_i(clk), .rst_ni, .cmd_we_i, .cmd_i, .pkt_sel_i, .rx_alloc_i, .rx_pages_i,
    .rx_drop_o, .tx_done_i, .tx_done_pkt_i, .tx_ok_i, .tx_req_o, .tx_pkt_o,
    .busy_o, .alloc_done_o, .alloc_res_o, .fifo_status_o, .mem_info_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic host_cmd(input logic [7:0] c);
    cmd_i = c; cmd_we_i = 1'b1;
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic alloc(input int n);
    host_cmd(8'h20 | 8'(n - 1));
    check("R2 busy", int'(busy_o), 1);
    @(negedge clk);
  endtask

  task automatic enq(input int p);
    pkt_sel_i = 7'(p);
    host_cmd(8'hC0);
  endtask

  task automatic tx_fin(input int p, input logic ok);
    tx_done_pkt_i = 7'(p); tx_ok_i = ok; tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
  endtask

  task automatic rx_req(input int n);
    rx_pages_i = 5'(n - 1); rx_alloc_i = 1'b1;
    @(negedge clk);
    rx_alloc_i = 1'b0;
  endtask

  function automatic int free_pg();
    return int'(mem_info_o[15:8]);
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check("R1 busy", int'(busy_o), 0);
    check("R1 mem", int'(mem_info_o), 16'h2020);
    check("R1 fifo", int'(fifo_status_o), 16'h8080);
    check("R1 res", int'(alloc_res_o), 0);
    check("R1 pulses", int'({alloc_done_o, tx_req_o, rx_drop_o}), 0);

    // R2 R4: growing page counts
    for (int k = 1; k <= 7; k++) begin
      alloc(k);
      check("R2 res", int'(alloc_res_o), k - 1);
      check("R4 free", free_pg(), PG - k * (k + 1) / 2);
      check("R3 no pulse on immediate", int'(alloc_done_o), 0);
    end
    // R3: 8 pages with 4 free
    alloc(8);
    check("R3 fail flag", int'(alloc_res_o), 8'h80);
    check("R3 busy after fail", int'(busy_o), 0);
    check("R4 free unchanged", free_pg(), 4);

    // R7
    enq(6);
    check("R7 tx_req", int'(tx_req_o), 1);
    check("R7 tx_pkt", int'(tx_pkt_o), 6);
    @(negedge clk);
    check("R7 pulse width", int'(tx_req_o), 0);

    // R8 R3: good send frees, pending then succeeds
    tx_fin(6, 1'b1);
    check("R8 freed", free_pg(), 11);
    check("R3 not yet", int'(alloc_done_o), 0);
    @(negedge clk);
    check("R3 done pulse", int'(alloc_done_o), 1);
    check("R3 late res", int'(alloc_res_o), 6);
    check("R4 after late", free_pg(), 3);
    @(negedge clk);
    check("R3 pulse width", int'(alloc_done_o), 0);

    // R7: free packet selected is ignored
    enq(12);
    check("R7 ignored", int'(tx_req_o), 0);

    // R5
    rx_req(2);
    check("R5 rx fifo", int'(fifo_status_o), 16'h0780);
    check("R5 free", free_pg(), 1);
    check("R5 no drop", int'(rx_drop_o), 0);
    rx_req(2);
    check("R5 drop", int'(rx_drop_o), 1);
    check("R5 fifo kept", int'(fifo_status_o), 16'h0780);

    // R6
    host_cmd(8'hA0);
    check("R6 free pop", free_pg(), 3);
    check("R6 empty", int'(fifo_status_o), 16'h8080);
    rx_req(1);
    check("R5 free 2", free_pg(), 2);
    host_cmd(8'h80);
    check("R6 release fifo", int'(fifo_status_o), 16'h8080);
    check("R6 release keeps pages", free_pg(), 2);
    host_cmd(8'hA0);
    check("R6 empty no effect", free_pg(), 2);

    // R8 R9
    enq(7);
    check("R7 tx_pkt 7", int'(tx_pkt_o), 7);
    tx_fin(7, 1'b0);
    check("R8 txd fifo", int'(fifo_status_o), 16'h8007);
    check("R8 not freed", free_pg(), 2);
    enq(5);
    host_cmd(8'hE0);
    check("R9 fifo", int'(fifo_status_o), 16'h8080);
    check("R9 free", free_pg(), 9);

    // pending across reset (R10)
    alloc(8);
    check("R2 res 5", int'(alloc_res_o), 5);
    alloc(4);
    check("R3 fail 2", int'(alloc_res_o), 8'h80);

    // R10 R11
    host_cmd(8'h40);
    bc = int'(busy_o);
    host_cmd(8'h21);
    bc += int'(busy_o);
    rx_req(1);
    check("R10 rx dropped", int'(rx_drop_o), 1);
    bc += int'(busy_o);
    for (int i = 0; i < 100; i++) begin
      if (!busy_o) break;
      @(negedge clk);
      if (busy_o) bc++;
    end
    check("R10 busy cycles", bc, NP);
    check("R10 all free", free_pg(), PG);
    check("R10 fifos", int'(fifo_status_o), 16'h8080);
    repeat (3) begin
      @(negedge clk);
      check("R11 no late alloc", int'(alloc_done_o), 0);
    end
    check("R11 pool untouched", free_pg(), PG);

    // R3: packet number exhaustion
    for (int i = 0; i < NP; i++) begin
      alloc(1);
      check("R2 seq res", int'(alloc_res_o), i);
      check("R4 seq free", free_pg(), PG - i - 1);
    end
    alloc(1);
    check("R3 no number", int'(alloc_res_o), 8'h80);
    enq(3);
    tx_fin(3, 1'b1);
    check("R8 freed 3", free_pg(), PG - NP + 1);
    @(negedge clk);
    check("R3 done 3", int'(alloc_done_o), 1);
    check("R3 res 3", int'(alloc_res_o), 3);
    check("R4 free end", free_pg(), PG - NP);

    report();
  end
endmodule